// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Engine

This block decides whether a received CAN identifier should be kept. It walks a table in a small lookup RAM one 32-bit word per clock and stops at the first match. Software builds the table while the filter is switched off. The table is split into five ordered sections. The byte offsets that bound each section live in five offset registers. Standard (11-bit) identifiers are checked against the direct-buffer list, the standard list and the standard ranges. Extended (29-bit) identifiers are checked against the extended list and the extended ranges.

The filter has three modes. In bypass mode every identifier is accepted. In table mode the lists and ranges are searched but the direct-buffer section is skipped. In direct-buffer mode that first section is searched as well, and a hit there returns the entry index and the byte address of that entry's 12-byte message slot. The slots sit right after the end of the table. A hit of this kind means the frame bypasses the general receive path. The receive logic presents each identifier with a valid strobe while the engine is ready, then waits for the done strobe and the result.

Top module: `can_acf_engine`

## Requirements
- R1: After reset all five offsets are zero, `ready_o` is high and `done_o` is low. With zero offsets, any search in a table mode finishes on the capture edge with a reject.
- R2: With `mode_i` = 2'b00 (bypass), every identifier is accepted with no direct-buffer hit, and `done_o` rises on the edge that captures the identifier.
- R3: The offset registers hold byte offsets from the base of the RAM. Select codes are 0 = standard list start, 1 = standard range start, 2 = extended list start, 3 = extended range start, 4 = table end. The direct-buffer section always starts at 0. The search uses the offsets at word granularity, so bits [1:0] are ignored. An empty section is one whose start equals the next start.
- R4: A standard list word holds two identifiers, in bits [26:16] and [10:0]. The upper halfword is earlier in order and is compared first.
- R5: A standard range word holds the lower bound in bits [26:16] and the upper bound in bits [10:0]. An identifier equal to either bound, or between them, is accepted.
- R6: An extended list word holds one identifier in bits [28:0]. An extended range takes two consecutive words, lower bound first, and both bounds are inclusive.
- R7: A standard identifier (`ext_i` = 0) is never matched against the extended sections. An extended identifier is never matched against the direct-buffer or standard sections.
- R8: In modes 2'b10 and 2'b11 the direct-buffer section is searched. Entry index k is 2×word + 1 for the lower halfword and 2×word for the upper halfword. A hit raises `dbuf_hit_o` and `accept_o`, gives k on `slot_o`, and gives table end + 12×k on `slot_addr_o`. Mode 2'b01 skips that section.
- R9: The search examines one word per clock, starting at the first applicable word and stopping at the first hit. When n words have been examined, `done_o` is high after the n-th edge that follows the capture edge.
- R10: `ready_o` is low while a search runs. An `id_valid_i` pulse during that time is ignored and does not change the pending result.
- R11: Writes to the RAM and to the offset registers take effect only while `mode_i` = 2'b00. In any other mode they are ignored.
- R12: An identifier found in no applicable section is rejected, with `accept_o` and `dbuf_hit_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 bypass, 01 table, 10/11 table with direct-buffer section |
| id_valid_i | input | 1 | Identifier strobe, taken when ready_o is high |
| id_i | input | 29 | Identifier; bits [10:0] are used for standard frames |
| ext_i | input | 1 | 1 = extended identifier |
| ram_we_i | input | 1 | Lookup RAM write enable |
| ram_addr_i | input | ADDR_W | Lookup RAM word address |
| ram_wdata_i | input | 32 | Lookup RAM write data |
| ofs_we_i | input | 1 | Offset register write enable |
| ofs_sel_i | input | 3 | Offset register select (R3) |
| ofs_wdata_i | input | OFS_W | Byte offset write data |
| ready_o | output | 1 | Engine idle, can take an identifier |
| done_o | output | 1 | One-cycle strobe: result valid |
| accept_o | output | 1 | Identifier accepted |
| dbuf_hit_o | output | 1 | Hit in the direct-buffer section |
| slot_o | output | SLOT_W | Direct-buffer entry index |
| slot_addr_o | output | SADDR_W | Byte address of the message slot |

## Verification
Every standard identifier is swept in direct-buffer mode against a table whose range bounds, halfword pairs and section edges are all hit exactly. A reversed halfword order would return the wrong slot index, and an exclusive range would reject 0x200 or 0x230. The bench checks the latency of each search against a count of the words walked. A walk that starts at the wrong section, or that does not stop at the first hit, therefore shows up as a timing error even when the verdict happens to be correct. Further tests cover the following:
- A word holding the same identifier in both halves, to confirm the upper half wins.
- Table writes made while the filter is running, which must change nothing.
- Extended identifiers whose values coincide with standard entries, which must be rejected.
- A strobe sent while the engine is busy, which must not disturb the result pending at the time.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;

  localparam int STD_W    = 11;
  localparam int EXT_W    = 29;
  localparam int NUM_OFS  = 5;

  // offset register select codes
  localparam logic [2:0] OFS_STD  = 3'd0;
  localparam logic [2:0] OFS_SRNG = 3'd1;
  localparam logic [2:0] OFS_EXT  = 3'd2;
  localparam logic [2:0] OFS_ERNG = 3'd3;
  localparam logic [2:0] OFS_END  = 3'd4;

  localparam logic [1:0] MODE_OFF = 2'b00;

  typedef enum logic [2:0] {
    SEC_DBUF,
    SEC_STD,
    SEC_SRNG,
    SEC_EXT,
    SEC_ERNG,
    SEC_NONE
  } sect_e;

  typedef enum logic {
    ST_IDLE,
    ST_WALK
  } walk_state_e;

endpackage

// File: rtl/can_acf_ram.sv
module can_acf_ram #(
  parameter int WORDS  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [31:0]       wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [31:0]       rdata_o
);

  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/can_acf_regs.sv
module can_acf_regs
  import can_acf_pkg::*;
#(
  parameter int OFS_W = 9
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [2:0]                      sel_i,
  input  logic [OFS_W-1:0]                wdata_i,
  output logic [NUM_OFS-1:0][OFS_W-1:0]   ofs_o
);

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
    logic [OFS_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        q <= '0;
      else if (we_i && sel_i == 3'(g))    q <= wdata_i;
    end
    assign ofs_o[g] = q;
  end

endmodule

// File: rtl/can_acf_match.sv
module can_acf_match
  import can_acf_pkg::*;
(
  input  sect_e             sect_i,
  input  logic [31:0]       word_i,
  input  logic [EXT_W-1:0]  id_i,
  input  logic [EXT_W-1:0]  lo_bound_i,
  input  logic              second_i,
  output logic              hit_o,
  output logic              lo_half_o
);

  logic [STD_W-1:0] id_s, hi_h, lo_h;
  logic             hi_eq, lo_eq;

  assign id_s  = id_i[STD_W-1:0];
  assign hi_h  = word_i[16 +: STD_W];
  assign lo_h  = word_i[0 +: STD_W];
  assign hi_eq = (hi_h == id_s);
  assign lo_eq = (lo_h == id_s);

  always_comb begin
    hit_o     = 1'b0;
    lo_half_o = 1'b0;
    unique case (sect_i)
      SEC_DBUF, SEC_STD: begin
        hit_o     = hi_eq | lo_eq;
        lo_half_o = !hi_eq && lo_eq;  // upper half has priority
      end
      SEC_SRNG: hit_o = (id_s >= hi_h) && (id_s <= lo_h);
      SEC_EXT:  hit_o = (word_i[EXT_W-1:0] == id_i);
      SEC_ERNG: hit_o = second_i && (id_i >= lo_bound_i) && (id_i <= word_i[EXT_W-1:0]);
      default: ;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{word_i[31:29], word_i[15:11]};

endmodule

// File: rtl/can_acf_engine.sv
module can_acf_engine
  import can_acf_pkg::*;
#(
  parameter  int RAM_WORDS = 64,
  localparam int ADDR_W    = $clog2(RAM_WORDS),
  localparam int OFS_W     = ADDR_W + 3,
  localparam int SLOT_W    = ADDR_W + 1,
  localparam int SADDR_W   = ADDR_W + 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic               id_valid_i,
  input  logic [EXT_W-1:0]   id_i,
  input  logic               ext_i,
  input  logic               ram_we_i,
  input  logic [ADDR_W-1:0]  ram_addr_i,
  input  logic [31:0]        ram_wdata_i,
  input  logic               ofs_we_i,
  input  logic [2:0]         ofs_sel_i,
  input  logic [OFS_W-1:0]   ofs_wdata_i,
  output logic               ready_o,
  output logic               done_o,
  output logic               accept_o,
  output logic               dbuf_hit_o,
  output logic [SLOT_W-1:0]  slot_o,
  output logic [SADDR_W-1:0] slot_addr_o
);

  localparam int PW = ADDR_W + 1;  // word pointer, reaches RAM_WORDS

  logic                         wr_ok;
  logic [NUM_OFS-1:0][OFS_W-1:0] ofs_all;
  logic [PW-1:0] w_std, w_srng, w_ext, w_erng, w_end;

  assign wr_ok = (mode_i == MODE_OFF);

  can_acf_regs #(.OFS_W(OFS_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ofs_we_i && wr_ok),
    .sel_i   (ofs_sel_i),
    .wdata_i (ofs_wdata_i),
    .ofs_o   (ofs_all)
  );

  assign w_std  = ofs_all[OFS_STD][OFS_W-1:2];
  assign w_srng = ofs_all[OFS_SRNG][OFS_W-1:2];
  assign w_ext  = ofs_all[OFS_EXT][OFS_W-1:2];
  assign w_erng = ofs_all[OFS_ERNG][OFS_W-1:2];
  assign w_end  = ofs_all[OFS_END][OFS_W-1:2];

  walk_state_e      state_q;
  logic [PW-1:0]    ptr_q, last_q, rd_ptr;
  logic [PW-1:0]    st_start, st_stop, erel;
  logic [EXT_W-1:0] id_q, lo_q;
  logic [31:0]      rdata;
  sect_e            sect;
  logic             hit, lo_half, second;

  // launch window: extended frames walk only the extended sections
  assign st_start = ext_i ? w_ext : (mode_i[1] ? '0 : w_std);
  assign st_stop  = ext_i ? w_end : w_ext;
  assign rd_ptr   = (state_q == ST_IDLE) ? st_start : ptr_q + PW'(1);

  can_acf_ram #(.WORDS(RAM_WORDS), .ADDR_W(ADDR_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we_i && wr_ok),
    .waddr_i (ram_addr_i),
    .wdata_i (ram_wdata_i),
    .raddr_i (rd_ptr[ADDR_W-1:0]),
    .rdata_o (rdata)
  );

  always_comb begin
    if      (ptr_q < w_std)  sect = SEC_DBUF;
    else if (ptr_q < w_srng) sect = SEC_STD;
    else if (ptr_q < w_ext)  sect = SEC_SRNG;
    else if (ptr_q < w_erng) sect = SEC_EXT;
    else if (ptr_q < w_end)  sect = SEC_ERNG;
    else                     sect = SEC_NONE;
  end

  assign erel   = ptr_q - w_erng;
  assign second = erel[0];

  can_acf_match u_match (
    .sect_i     (sect),
    .word_i     (rdata),
    .id_i       (id_q),
    .lo_bound_i (lo_q),
    .second_i   (second),
    .hit_o      (hit),
    .lo_half_o  (lo_half)
  );

  logic [SLOT_W-1:0]  k_idx;
  logic [SADDR_W-1:0] k_addr;
  assign k_idx  = {ptr_q[ADDR_W-1:0], lo_half};
  assign k_addr = SADDR_W'(ofs_all[OFS_END])
                + (SADDR_W'(k_idx) << 3) + (SADDR_W'(k_idx) << 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ptr_q       <= '0;
      last_q      <= '0;
      id_q        <= '0;
      lo_q        <= '0;
      done_o      <= 1'b0;
      accept_o    <= 1'b0;
      dbuf_hit_o  <= 1'b0;
      slot_o      <= '0;
      slot_addr_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (id_valid_i) begin
            id_q <= ext_i ? id_i : EXT_W'(id_i[STD_W-1:0]);
            if (mode_i == MODE_OFF) begin
              done_o      <= 1'b1;
              accept_o    <= 1'b1;
              dbuf_hit_o  <= 1'b0;
              slot_o      <= '0;
              slot_addr_o <= '0;
            end else if (st_start >= st_stop) begin
              done_o      <= 1'b1;
              accept_o    <= 1'b0;
              dbuf_hit_o  <= 1'b0;
              slot_o      <= '0;
              slot_addr_o <= '0;
            end else begin
              state_q <= ST_WALK;
              ptr_q   <= st_start;
              last_q  <= st_stop - PW'(1);
            end
          end
        end
        ST_WALK: begin
          if (sect == SEC_ERNG && !second) lo_q <= rdata[EXT_W-1:0];
          if (hit) begin
            state_q     <= ST_IDLE;
            done_o      <= 1'b1;
            accept_o    <= 1'b1;
            dbuf_hit_o  <= (sect == SEC_DBUF);
            slot_o      <= (sect == SEC_DBUF) ? k_idx : '0;
            slot_addr_o <= (sect == SEC_DBUF) ? k_addr : '0;
          end else if (ptr_q == last_q) begin
            state_q     <= ST_IDLE;
            done_o      <= 1'b1;
            accept_o    <= 1'b0;
            dbuf_hit_o  <= 1'b0;
            slot_o      <= '0;
            slot_addr_o <= '0;
          end else begin
            ptr_q <= ptr_q + PW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == ST_IDLE);

  logic unused_ofs;
  assign unused_ofs = ^{ofs_all[OFS_STD][1:0], ofs_all[OFS_SRNG][1:0],
                        ofs_all[OFS_EXT][1:0], ofs_all[OFS_ERNG][1:0]};

endmodule

// File: rtl/can_acf_chk.sv
module can_acf_chk
  import can_acf_pkg::*;
#(
  parameter  int RAM_WORDS = 64,
  localparam int ADDR_W    = $clog2(RAM_WORDS),
  localparam int OFS_W     = ADDR_W + 3,
  localparam int SLOT_W    = ADDR_W + 1,
  localparam int SADDR_W   = ADDR_W + 5
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [1:0]                    mode_i,
  input logic                          id_valid_i,
  input logic                          ready_o,
  input logic                          done_o,
  input logic                          accept_o,
  input logic                          dbuf_hit_o,
  input logic [SLOT_W-1:0]             slot_o,
  input logic [SADDR_W-1:0]            slot_addr_o,
  input logic [NUM_OFS-1:0][OFS_W-1:0] ofs_all_i
);

  // R2
  bypass_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_i && ready_o && mode_i == MODE_OFF |=> done_o && accept_o && !dbuf_hit_o);

  // R8
  dbuf_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && dbuf_hit_o |-> accept_o);

  // R8
  slot_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && dbuf_hit_o |->
      slot_addr_o == SADDR_W'(ofs_all_i[OFS_END]) + SADDR_W'(slot_o) * SADDR_W'(12));

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  // R10
  launch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_i && ready_o |=> !ready_o || done_o);

  // R11
  ofs_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i != MODE_OFF |=> $stable(ofs_all_i));

endmodule

bind can_acf_engine can_acf_chk #(.RAM_WORDS(RAM_WORDS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .id_valid_i  (id_valid_i),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .accept_o    (accept_o),
  .dbuf_hit_o  (dbuf_hit_o),
  .slot_o      (slot_o),
  .slot_addr_o (slot_addr_o),
  .ofs_all_i   (ofs_all)
);

// File: tb/can_acf_engine_tb.sv
module can_acf_engine_tb;

  localparam int RW  = 64;
  localparam int AW  = 6;
  localparam int OW  = 9;
  localparam int SW  = 7;
  localparam int SAW = 11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode = 2'b00;
  logic            id_valid = 1'b0;
  logic [28:0]     id = '0;
  logic            ext = 1'b0;
  logic            ram_we = 1'b0;
  logic [AW-1:0]   ram_addr = '0;
  logic [31:0]     ram_wdata = '0;
  logic            ofs_we = 1'b0;
  logic [2:0]      ofs_sel = '0;
  logic [OW-1:0]   ofs_wdata = '0;
  logic            ready, done, accept, dbuf_hit;
  logic [SW-1:0]   slot;
  logic [SAW-1:0]  slot_addr;

  always #4 clk = ~clk;

  can_acf_engine #(.RAM_WORDS(RW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .id_valid_i(id_valid),
    .id_i(id), .ext_i(ext), .ram_we_i(ram_we), .ram_addr_i(ram_addr),
    .ram_wdata_i(ram_wdata), .ofs_we_i(ofs_we), .ofs_sel_i(ofs_sel),
    .ofs_wdata_i(ofs_wdata), .ready_o(ready), .done_o(done),
    .accept_o(accept), .dbuf_hit_o(dbuf_hit), .slot_o(slot),
    .slot_addr_o(slot_addr)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] tbl [RW];
  int ofs_m [5];

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic put_word(input int a, input logic [31:0] d);
    @(negedge clk);
    ram_we = 1'b1; ram_addr = AW'(a); ram_wdata = d;
    @(negedge clk);
    ram_we = 1'b0;
    if (mode == 2'b00) tbl[a] = d;
  endtask

  task automatic put_ofs(input int sel, input int v);
    @(negedge clk);
    ofs_we = 1'b1; ofs_sel = 3'(sel); ofs_wdata = OW'(v);
    @(negedge clk);
    ofs_we = 1'b0;
    if (mode == 2'b00) ofs_m[sel] = v;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
  endtask

  // reference: sequential walk over the bench's own copy of the table
  task automatic ref_model(input logic [28:0] rid, input logic rext,
                           output logic acc, output logic dbh,
                           output int rslot, output int raddr, output int lat);
    int ws [5];
    int s, e;
    logic [10:0] i11;
    i11 = rid[10:0];
    acc = 1'b0; dbh = 1'b0; rslot = 0; raddr = 0; lat = 0;
    if (mode == 2'b00) begin acc = 1'b1; return; end
    for (int j = 0; j < 5; j++) ws[j] = ofs_m[j] / 4;
    s = rext ? ws[2] : (mode[1] ? 0 : ws[0]);
    e = rext ? ws[4] : ws[2];
    for (int w = s; w < e; w++) begin
      logic [31:0] d;
      logic h, lo;
      d = tbl[w]; h = 1'b0; lo = 1'b0;
      if (!rext) begin
        if (w < ws[1]) begin
          if (d[26:16] == i11) h = 1'b1;
          else if (d[10:0] == i11) begin h = 1'b1; lo = 1'b1; end
        end else if (i11 >= d[26:16] && i11 <= d[10:0]) h = 1'b1;
      end else begin
        if (w < ws[3]) h = (d[28:0] == rid);
        else if (((w - ws[3]) % 2) == 1)
          h = (rid >= tbl[w-1][28:0]) && (rid <= d[28:0]);
      end
      if (h) begin
        acc = 1'b1;
        lat = w - s + 1;
        if (!rext && w < ws[0]) begin
          dbh = 1'b1;
          rslot = 2 * w + int'(lo);
          raddr = ofs_m[4] + 12 * rslot;
        end
        return;
      end
    end
    lat = (e > s) ? e - s : 0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic compare(input logic [28:0] rid, input logic rext,
                         input string tag, input int cyc);
    logic eacc, edbh;
    int eslot, eaddr, elat;
    bit ok;
    ref_model(rid, rext, eacc, edbh, eslot, eaddr, elat);
    ok = done && accept == eacc && dbuf_hit == edbh && cyc == elat &&
         (!edbh || (int'(slot) == eslot && int'(slot_addr) == eaddr));
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s id=%h ext=%0d: actual acc=%0d dbuf=%0d slot=%0d addr=%0d lat=%0d expected acc=%0d dbuf=%0d slot=%0d addr=%0d lat=%0d",
               tag, rid, rext, accept, dbuf_hit, slot, slot_addr, cyc,
               eacc, edbh, eslot, eaddr, elat);
    end
  endtask

  task automatic run(input logic [28:0] rid, input logic rext, input string tag);
    int cyc;
    @(negedge clk);
    id = rid; ext = rext; id_valid = 1'b1;
    @(negedge clk);
    id_valid = 1'b0;
    wait_done(cyc);
    compare(rid, rext, tag, cyc);
  endtask

  localparam int N_EXT = 14;
  localparam logic [28:0] EXT_IDS [N_EXT] = '{
    29'h7500, 29'h8500, 29'h7501, 29'h84FF, 29'hA000, 29'h9FFF, 29'hB000,
    29'hB001, 29'hA800, 29'h100, 29'h110, 29'h205, 29'h1FFFFFFF, 29'h0};

  initial begin
    #(8 * 190000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < RW; i++) tbl[i] = '0;
    for (int i = 0; i < 5; i++) ofs_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    set_mode(2'b01);
    run(29'h100, 1'b0, "R1");
    run(29'h7500, 1'b1, "R1");
    set_mode(2'b10);
    run(29'h100, 1'b0, "R1");

    // build table in bypass mode
    set_mode(2'b00);
    put_word(0, {16'h0100, 16'h0101});
    put_word(1, {16'h0102, 16'h0103});
    put_word(2, {16'h0110, 16'h0120});
    put_word(3, {16'h0130, 16'h0140});
    put_word(4, {16'h0200, 16'h0210});
    put_word(5, {16'h0220, 16'h0230});
    put_word(6, 32'h0000_7500);
    put_word(7, 32'h0000_8500);
    put_word(8, 32'h0000_A000);
    put_word(9, 32'h0000_B000);
    put_ofs(0, 8);
    put_ofs(1, 16);
    put_ofs(2, 24);
    put_ofs(3, 32);
    put_ofs(4, 40);

    // R2 bypass
    run(29'h7FF, 1'b0, "R2");
    run(29'h1ABCDEF, 1'b1, "R2");
    run(29'h111, 1'b0, "R2");

    set_mode(2'b10);
    // R8 direct-buffer slots
    run(29'h100, 1'b0, "R8");
    run(29'h101, 1'b0, "R8");
    run(29'h103, 1'b0, "R8");
    // R4 packed standard entries
    run(29'h110, 1'b0, "R4");
    run(29'h140, 1'b0, "R4");
    // R5 inclusive ranges
    run(29'h200, 1'b0, "R5");
    run(29'h210, 1'b0, "R5");
    run(29'h211, 1'b0, "R5");
    run(29'h230, 1'b0, "R5");
    run(29'h21F, 1'b0, "R5");
    // R12 absent
    run(29'h111, 1'b0, "R12");
    run(29'h0FF, 1'b0, "R12");
    // R6 / R7 extended
    for (int i = 0; i < N_EXT; i++) run(EXT_IDS[i], 1'b1, (i < 9) ? "R6" : "R7");
    // R9 latency over every standard identifier
    for (int v = 0; v < 2048; v++) run(29'(v), 1'b0, "R9");

    // R8 mode 01 skips the direct-buffer section
    set_mode(2'b01);
    run(29'h100, 1'b0, "R8");
    run(29'h102, 1'b0, "R8");
    run(29'h130, 1'b0, "R3");
    run(29'hA800, 1'b1, "R6");

    // R10 strobe while busy is ignored
    set_mode(2'b10);
    begin
      int cyc;
      @(negedge clk);
      id = 29'h230; ext = 1'b0; id_valid = 1'b1;
      @(negedge clk);
      chk(ready == 1'b0, "R10", "ready during walk", int'(ready), 0);
      id = 29'h100;
      wait_done(cyc);
      id_valid = 1'b0;
      compare(29'h230, 1'b0, "R10", cyc);
      @(negedge clk);
      chk(ready == 1'b1 && done == 1'b0, "R10", "idle after busy strobe",
          int'({ready, done}), 2);
    end

    // R11 writes outside bypass mode are ignored
    put_word(2, {16'h0111, 16'h0111});
    put_ofs(4, 0);
    run(29'h111, 1'b0, "R11");
    run(29'h101, 1'b0, "R11");

    // R4 upper halfword wins when both halves match; R3 offset low bits ignored
    set_mode(2'b00);
    put_word(1, {16'h0105, 16'h0105});
    put_ofs(0, 9);
    set_mode(2'b10);
    run(29'h105, 1'b0, "R4");
    run(29'h110, 1'b0, "R3");

    report();
    $finish;
  end

endmodule